// File: doc/BRIEF.md
# Indirect Control-Port Write Sequencer

This block performs one indirect register write into a PHY's internal control-register port. A host raises `start` for one cycle and supplies a 16-bit target address and 16-bit write value. The block then runs three request/acknowledge handshakes in a fixed order. The first captures the address. The second captures the data. The third commits the write.

In each handshake the block presents a value on `port_din`, raises exactly one strobe and waits for the acknowledge. It then drops the strobe with the bus held, and waits for the acknowledge to return low. The acknowledge comes from another clock domain, so it passes through a two-flop synchronizer before the sequencer uses it.

Every wait has a cycle-counted time limit. When a limit runs out, the remaining phases are abandoned. The block then reports an error code that tells which phase stalled and which acknowledge edge never arrived. A successful write ends with a one-cycle `done` pulse.

Top module: `ctlp_write_master`

## Requirements
- R1: After synchronous reset, all three strobes are low, `port_din` is zero, and `busy`, `done`, `error` and `err_code` are all zero.
- R2: A write runs three handshakes in this order. The first puts the address on the bus with `cap_addr_stb`. The second puts the write value on the bus with `cap_data_stb`. The third keeps the write value on the bus with `wr_stb`.
- R3: No more than one strobe is high in any cycle.
- R4: A strobe falls in the cycle after the synchronized acknowledge is seen high, and `port_din` stays unchanged while the sequencer waits for the acknowledge to go low.
- R5: Before each capture handshake, the value to be captured sits on `port_din` for one cycle with all strobes low. The strobe rises in the following cycle.
- R6: When the third handshake sees the synchronized acknowledge low, `done` is high for exactly one cycle and `busy` falls in that same cycle.
- R7: Each wait lasts at most TIMEOUT cycles, counted from the cycle after the wait begins. On expiry, `err_code` holds the phase in bits [2:1] (0 address, 1 data, 2 write) and the awaited edge in bit 0 (0 means waiting for high, 1 means waiting for low).
- R8: After a timeout, no later phase runs. All strobes are low, `busy` is low, and `error` stays high until the next accepted `start`, which clears it.
- R9: A `start` that arrives while `busy` is high has no effect on the transaction in progress, and it does not start another one.
- R10: The acknowledge input passes through two flip-flops before the sequencer acts on it. A strobe therefore falls no earlier than three cycles after the acknowledge rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a write (accepted only when idle) |
| addr | input | 16 | Target address in the control port |
| wdata | input | 16 | Value to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | Last transaction timed out |
| err_code | output | 3 | {phase[1:0], awaited edge} of the timeout |
| port_din | output | 16 | Data-in bus to the control port |
| cap_addr_stb | output | 1 | Capture-address strobe |
| cap_data_stb | output | 1 | Capture-data strobe |
| wr_stb | output | 1 | Write strobe |
| port_ack | input | 1 | Acknowledge from the control port (asynchronous) |

## Verification
Successful writes are driven with acknowledge response delays of one, three and six cycles. These runs confirm that the strobe timing follows the synchronized acknowledge and not a fixed cycle count. A second start is injected in the middle of a write; the values captured by the responder show whether the in-flight address or data was disturbed. The responder is then made to stall each edge in several phases: a missing rise in the address phase, a missing fall in the data phase, and both a missing rise and a missing fall in the write phase. These cases separate the phase bits from the edge bit of the error code and show that later phases are abandoned. A final clean write after an error checks that the error clears.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int ECODE_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WAIT_HI,
        ST_WAIT_LO
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_ADDR  = 2'd0,
        PH_DATA  = 2'd1,
        PH_WRITE = 2'd2
    } phase_t;

    typedef struct packed {
        logic wr;
        logic cdata;
        logic caddr;
    } strobe_t;

    function automatic strobe_t strobe_for(phase_t p);
        strobe_t s;
        s = '0;
        case (p)
            PH_ADDR:  s.caddr = 1'b1;
            PH_DATA:  s.cdata = 1'b1;
            default:  s.wr    = 1'b1;
        endcase
        return s;
    endfunction

    function automatic logic [ECODE_W-1:0] err_code_f(phase_t p, logic lo_wait);
        return {p, lo_wait};
    endfunction

endpackage

// File: rtl/ctlp_sync.sv
module ctlp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ctlp_timer.sv
module ctlp_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] RELOAD = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                    cnt <= RELOAD;
        else if (load)              cnt <= RELOAD;
        else if (run && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == RELOAD)) else $error("timer reload"); // R7
endmodule

// File: rtl/ctlp_seq.sv
module ctlp_seq
    import ctlp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 ack_s,
    input  logic                 tmr_expired,
    output logic                 tmr_load,
    output logic                 tmr_run,
    output logic                 busy,
    output logic                 done,
    output logic                 error,
    output logic [ECODE_W-1:0]   err_code,
    output logic [DATA_W-1:0]    port_din,
    output strobe_t              strobes
);
    seq_state_t          state;
    phase_t              phase;
    logic [DATA_W-1:0]   data_q;

    always_comb begin
        tmr_load = 1'b0;
        tmr_run  = 1'b0;
        case (state)
            ST_SETUP:   tmr_load = 1'b1;
            ST_WAIT_HI: begin
                tmr_load = ack_s;
                tmr_run  = !ack_s;
            end
            ST_WAIT_LO: tmr_run = ack_s;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            phase    <= PH_ADDR;
            data_q   <= '0;
            port_din <= '0;
            strobes  <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            error    <= 1'b0;
            err_code <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        data_q   <= wdata;
                        port_din <= DATA_W'(addr);
                        phase    <= PH_ADDR;
                        busy     <= 1'b1;
                        error    <= 1'b0;
                        err_code <= '0;
                        state    <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    strobes <= strobe_for(phase);
                    state   <= ST_WAIT_HI;
                end
                ST_WAIT_HI: begin
                    if (ack_s) begin
                        strobes <= '0;
                        state   <= ST_WAIT_LO;
                    end else if (tmr_expired) begin
                        strobes  <= '0;
                        busy     <= 1'b0;
                        error    <= 1'b1;
                        err_code <= err_code_f(phase, 1'b0);
                        state    <= ST_IDLE;
                    end
                end
                ST_WAIT_LO: begin
                    if (!ack_s) begin
                        if (phase == PH_WRITE) begin
                            busy  <= 1'b0;
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            phase    <= phase_t'(phase + 2'd1);
                            port_din <= data_q;
                            state    <= ST_SETUP;
                        end
                    end else if (tmr_expired) begin
                        busy     <= 1'b0;
                        error    <= 1'b1;
                        err_code <= err_code_f(phase, 1'b1);
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobes)) else $error("strobe overlap"); // R3
    AST_BUS_HELD_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(|strobes) |-> $stable(port_din)) else $error("bus moved"); // R4
    AST_BUS_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(|strobes) |-> $stable(port_din)) else $error("bus late"); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done width"); // R6
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy) else $error("done busy"); // R6
    AST_HI_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_HI && !ack_s && tmr_expired) |=> (error && !err_code[0]))
        else $error("hi timeout"); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (strobes == '0)) else $error("strobe idle"); // R8
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
        error |-> !busy) else $error("error busy"); // R8
endmodule

// File: rtl/ctlp_write_master.sv
module ctlp_write_master
    import ctlp_pkg::*;
#(
    parameter int TIMEOUT     = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [15:0]         addr,
    input  logic [15:0]         wdata,
    output logic                busy,
    output logic                done,
    output logic                error,
    output logic [2:0]          err_code,
    output logic [15:0]         port_din,
    output logic                cap_addr_stb,
    output logic                cap_data_stb,
    output logic                wr_stb,
    input  logic                port_ack
);
    logic    ack_s;
    logic    tmr_load;
    logic    tmr_run;
    logic    tmr_expired;
    strobe_t strobes;

    ctlp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (port_ack),
        .q   (ack_s)
    );

    ctlp_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    ctlp_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .addr        (addr),
        .wdata       (wdata),
        .ack_s       (ack_s),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_run     (tmr_run),
        .busy        (busy),
        .done        (done),
        .error       (error),
        .err_code    (err_code),
        .port_din    (port_din),
        .strobes     (strobes)
    );

    assign cap_addr_stb = strobes.caddr;
    assign cap_data_stb = strobes.cdata;
    assign wr_stb       = strobes.wr;

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $rose(port_ack) |=> (strobes == $past(strobes))) else $error("sync bypass"); // R10
endmodule

// File: tb/ctlp_write_master_test.sv
module ctlp_write_master_test;
    localparam int T = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [15:0] addr = '0, wdata = '0;
    logic busy, done, error;
    logic [2:0] err_code;
    logic [15:0] port_din;
    logic cap_addr_stb, cap_data_stb, wr_stb;
    logic port_ack = 1'b0;

    int checks = 0, errors = 0, cycles = 0;

    ctlp_write_master #(.TIMEOUT(T)) uut (
        .clk(clk), .rst(rst), .start(start), .addr(addr), .wdata(wdata),
        .busy(busy), .done(done), .error(error), .err_code(err_code),
        .port_din(port_din), .cap_addr_stb(cap_addr_stb),
        .cap_data_stb(cap_data_stb), .wr_stb(wr_stb), .port_ack(port_ack)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    int m_st = 0, m_ph = 0, m_w = 0;
    logic [15:0] m_d = '0, m_din = '0;
    logic [2:0] m_stb = '0;
    logic m_busy = 0, m_done = 0, m_err = 0;
    logic [2:0] m_code = '0;
    logic m_s1 = 0, m_s2 = 0;

    always @(posedge clk) begin
        logic a;
        a = m_s2;
        m_done = 1'b0;
        if (rst) begin
            m_st = 0; m_ph = 0; m_d = '0; m_din = '0; m_stb = '0;
            m_busy = 0; m_err = 0; m_code = '0; m_s1 = 0; m_s2 = 0;
        end else begin
            m_s2 = m_s1; m_s1 = port_ack;
            case (m_st)
                0: if (start) begin
                    m_d = wdata; m_din = addr; m_ph = 0; m_busy = 1;
                    m_err = 0; m_code = '0; m_st = 1;
                end
                1: begin m_stb = 3'(1 << m_ph); m_w = 1; m_st = 2; end
                2: if (a) begin m_stb = '0; m_w = 1; m_st = 3; end
                   else if (m_w == T) begin
                       m_stb = '0; m_busy = 0; m_err = 1;
                       m_code = {2'(m_ph), 1'b0}; m_st = 0;
                   end else m_w++;
                default: if (!a) begin
                       if (m_ph == 2) begin m_busy = 0; m_done = 1; m_st = 0; end
                       else begin m_ph++; m_din = m_d; m_st = 1; end
                   end else if (m_w == T) begin
                       m_busy = 0; m_err = 1; m_code = {2'(m_ph), 1'b1}; m_st = 0;
                   end else m_w++;
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk({wr_stb, cap_data_stb, cap_addr_stb} == m_stb, "R2", "strobes",
                {wr_stb, cap_data_stb, cap_addr_stb}, m_stb);
            chk(port_din == m_din, "R4", "port_din", port_din, m_din);
            chk(busy == m_busy && done == m_done, "R6", "busy/done",
                {busy, done}, {m_busy, m_done});
            chk(error == m_err && err_code == m_code, "R7", "error/code",
                {error, err_code}, {m_err, m_code});
        end
    end

    // responder standing in for the control port
    int dly = 1, rcnt = 0, fail_ph = -1, fail_lo = 0, lastph = 0, n_done = 0;
    logic [15:0] cap [3];
    always @(negedge clk) begin
        int ph;
        cycles++;
        if (done) n_done++;
        ph = cap_addr_stb ? 0 : cap_data_stb ? 1 : 2;
        if ((cap_addr_stb | cap_data_stb | wr_stb) && !port_ack) begin
            if (!(fail_ph == ph && fail_lo == 0)) begin
                rcnt++;
                if (rcnt >= dly) begin
                    port_ack <= 1'b1; rcnt = 0; cap[ph] = port_din; lastph = ph;
                end
            end
        end else if (!(cap_addr_stb | cap_data_stb | wr_stb) && port_ack) begin
            if (!(fail_ph == lastph && fail_lo == 1)) begin
                rcnt++;
                if (rcnt >= dly) begin port_ack <= 1'b0; rcnt = 0; end
            end
        end
    end

    task automatic run_write(input logic [15:0] a, input logic [15:0] d, input bit inject);
        @(negedge clk);
        addr = a; wdata = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        if (inject) begin
            addr = ~a; wdata = ~d; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic clean_ok(input logic [15:0] a, input logic [15:0] d, input string req);
        chk(cap[0] == a, req, "captured address", cap[0], a);
        chk(cap[1] == d, req, "captured data", cap[1], d);
        chk(cap[2] == d, req, "write-phase data", cap[2], d);
        chk(n_done == 1, "R6", "done pulses", n_done, 1);
        chk(!error, "R8", "error after clean write", error, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!cap_addr_stb && !cap_data_stb && !wr_stb && port_din == 0 && !busy
            && !done && !error && err_code == 0, "R1", "reset outputs",
            {busy, done, error, err_code}, 0);
        rst = 1'b0;

        // R2 R5 R10 plain writes with varying response delays
        dly = 1; n_done = 0; run_write(16'h1234, 16'hBEEF, 0); clean_ok(16'h1234, 16'hBEEF, "R2");
        dly = 3; n_done = 0; run_write(16'h0015, 16'hA009, 0); clean_ok(16'h0015, 16'hA009, "R10");
        dly = 6; n_done = 0; run_write(16'hFFFF, 16'h0000, 0); clean_ok(16'hFFFF, 16'h0000, "R5");

        // R9 start while busy is ignored
        dly = 2; n_done = 0; run_write(16'h1010, 16'h0080, 1); clean_ok(16'h1010, 16'h0080, "R9");
        chk(!busy, "R9", "no second transaction", busy, 0);

        // R7 R8 timeouts: phase 0 high wait, phase 1 low wait, phase 2 both edges
        dly = 1; fail_ph = 0; fail_lo = 0; n_done = 0; cap[1] = 16'h5555;
        run_write(16'h0012, 16'hA000, 0);
        chk(error && err_code == 3'b000, "R7", "addr hi timeout code", {error, err_code}, 4'b1000);
        chk(cap[1] == 16'h5555 && n_done == 0, "R8", "later phases abandoned", cap[1], 16'h5555);

        fail_ph = 1; fail_lo = 1; n_done = 0;
        run_write(16'h0022, 16'hC0DE, 0);
        chk(error && err_code == 3'b011, "R7", "data lo timeout code", {error, err_code}, 4'b1011);
        chk(!busy && n_done == 0, "R8", "idle after fail", busy, 0);
        fail_ph = -1; port_ack <= 1'b0; repeat (6) @(negedge clk);
        chk(error, "R8", "error held while idle", error, 1);

        fail_ph = 2; fail_lo = 0; n_done = 0;
        run_write(16'h0033, 16'h7777, 0);
        chk(error && err_code == 3'b100, "R7", "write hi timeout code", {error, err_code}, 4'b1100);

        fail_ph = 2; fail_lo = 1; n_done = 0;
        run_write(16'h0044, 16'h8888, 0);
        chk(error && err_code == 3'b101, "R7", "write lo timeout code", {error, err_code}, 4'b1101);
        fail_ph = -1; port_ack <= 1'b0; repeat (6) @(negedge clk);

        // R8 next start clears the error
        n_done = 0; run_write(16'h0101, 16'h0202, 0); clean_ok(16'h0101, 16'h0202, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 50000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule